// File: doc/BRIEF.md
# Prioritised interrupt flag controller

This block is the interrupt control register of a small 8-bit processor core. It watches four event sources: a one-cycle timer overflow pulse, an external pin with a selectable active edge, any change on a four-pin slice of an input port, and a write-complete flag raised by a memory controller outside the block. For each source it holds an enable bit. For three of the sources it also holds a sticky flag. A global enable sits above them all, and the block raises a single request line to the core.

When the core accepts a request, the block hands back a fixed vector address and the program counter to push. It then drops the global enable, so a second interrupt cannot nest. A return-from-interrupt strobe sets the global enable again. Software reads the whole register and writes it as one byte. A software write is the only thing that clears a flag.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the register reads 0x00, with the port-change flag reset value taken from a parameter (0 by default), and no request is raised.
- R2: A software write loads all eight bits: bit 7 global enable, bit 6 write-complete enable, bit 5 timer enable, bit 4 pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 pin flag, bit 0 port-change flag. The new value reads back one cycle later.
- R3: A timer overflow pulse sets bit 2 on the next clock, whatever the enables hold.
- R4: The pin flag (bit 1) sets on a rising pin edge when the edge-select input is 1, and on a falling edge when it is 0. The other edge leaves it at 0. The flag appears three clocks after the pin moves.
- R5: A change of state on any of the four port pins sets bit 0, three clocks after the change, in either direction.
- R6: Hardware never clears a flag. A set flag stays set until a software write clears it.
- R7: The request equals bit 7 AND the OR of (bit 6 AND write-complete input), (bit 5 AND bit 2), (bit 4 AND bit 1) and (bit 3 AND bit 0). It follows the write-complete input in the same cycle.
- R8: While bit 7 is 0, no request is raised, even with an enabled flag pending.
- R9: When the acknowledge input is high while the request is high, the take output is high in that cycle, the vector output is 0x004 and the push output carries the current program counter. Bit 7 reads 0 from the next cycle. An acknowledge with no request has no effect.
- R10: A return strobe sets bit 7 on the next clock.
- R11: When a software write and a hardware flag set fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Register contents |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| ext_rise_sel | input | 1 | 1: rising edge, 0: falling edge |
| port_pins | input | PORT_W | Watched port pins (asynchronous) |
| wc_flag | input | 1 | Write-complete flag from memory logic |
| cur_pc | input | PC_W | Return program counter from the core |
| irq_ack | input | 1 | Core accepts the interrupt |
| ret_strobe | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request |
| vec_take | output | 1 | Acceptance happening this cycle |
| vec_addr | output | PC_W | Vector fetch address |
| push_pc | output | PC_W | Program counter to push |

## Verification
The bench builds the block with a 13-bit program counter, vector 0x004, four port pins, two synchroniser stages and a port-change flag that resets to 0. With these values the three-clock path from a pin to its flag can be checked exactly, one clock before the flag and one clock after it. They also make a reset value of 0x00 a fixed expectation. The bench holds the program counter at a fixed value, so the pushed address can be compared on every check. It also drives acceptance, return, simultaneous write and set, and acknowledge with no request pending.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int B_GIE    = 7;
  localparam int B_WCE    = 6;
  localparam int B_TMRE   = 5;
  localparam int B_EXTE   = 4;
  localparam int B_PCHE   = 3;
  localparam int B_TMRF   = 2;
  localparam int B_EXTF   = 1;
  localparam int B_PCHF   = 0;
  localparam int N_FLAGS  = 3;

  // request: global gate over the enabled sources
  function automatic logic req_calc(input logic [REG_W-1:0] r, input logic wc);
    logic any;
    any = (r[B_WCE] & wc) | (r[B_TMRE] & r[B_TMRF]) |
          (r[B_EXTE] & r[B_EXTF]) | (r[B_PCHE] & r[B_PCHF]);
    return r[B_GIE] & any;
  endfunction

  // selected-edge match between the current and previous pin samples
  function automatic logic edge_match(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_event_detect.sv
`timescale 1ns/1ps
module irq_event_detect
  import irq_ctrl_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_s,
  input  logic [PORT_W-1:0] port_s,
  input  logic              rise_sel,
  output logic              ext_hit,
  output logic              chg_hit
);
  logic              ext_prev;
  logic [PORT_W-1:0] port_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev  <= 1'b0;
      port_prev <= '0;
    end else begin
      ext_prev  <= ext_s;
      port_prev <= port_s;
    end
  end

  assign ext_hit = edge_match(ext_s, ext_prev, rise_sel);
  assign chg_hit = |(port_s ^ port_prev);
endmodule

// File: rtl/irq_flag_reg.sv
`timescale 1ns/1ps
module irq_flag_reg
  import irq_ctrl_pkg::*;
#(
  parameter bit PCHF_RST = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sw_wr,
  input  logic [REG_W-1:0]   sw_wdata,
  input  logic [N_FLAGS-1:0] flag_set,
  input  logic               accept,
  input  logic               ret,
  output logic [REG_W-1:0]   q
);
  localparam logic [REG_W-1:0] RST_VAL = {{(REG_W-1){1'b0}}, PCHF_RST};

  logic [REG_W-1:0] base;
  assign base = sw_wr ? sw_wdata : q;

  // global enable: acceptance clears, then return sets, then software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q[B_GIE] <= RST_VAL[B_GIE];
    else if (accept) q[B_GIE] <= 1'b0;
    else if (ret)    q[B_GIE] <= 1'b1;
    else             q[B_GIE] <= base[B_GIE];
  end

  // enable bits: software only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q[B_WCE:B_PCHE] <= RST_VAL[B_WCE:B_PCHE];
    else        q[B_WCE:B_PCHE] <= base[B_WCE:B_PCHE];
  end

  // sticky flags: a hardware set overrides a software clear
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= RST_VAL[g];
      else        q[g] <= base[g] | flag_set[g];
    end
  end
endmodule

// File: rtl/irq_ctrl_unit.sv
`timescale 1ns/1ps
module irq_ctrl_unit
  import irq_ctrl_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int VEC_ADDR    = 4,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit PCHF_RST    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [7:0]        sw_wdata,
  output logic [7:0]        sw_rdata,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic              ext_rise_sel,
  input  logic [PORT_W-1:0] port_pins,
  input  logic              wc_flag,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              irq_ack,
  input  logic              ret_strobe,
  output logic              irq_req,
  output logic              vec_take,
  output logic [PC_W-1:0]   vec_addr,
  output logic [PC_W-1:0]   push_pc
);
  localparam int SYNC_W = PORT_W + 1;

  logic [SYNC_W-1:0]  pins_s;
  logic               ext_hit;
  logic               chg_hit;
  logic [N_FLAGS-1:0] flag_set;
  logic [REG_W-1:0]   reg_q;

  irq_pin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ext_pin, port_pins}),
    .q     (pins_s)
  );

  irq_event_detect #(.PORT_W(PORT_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_s    (pins_s[SYNC_W-1]),
    .port_s   (pins_s[PORT_W-1:0]),
    .rise_sel (ext_rise_sel),
    .ext_hit  (ext_hit),
    .chg_hit  (chg_hit)
  );

  assign flag_set[B_TMRF] = tmr_ovf;
  assign flag_set[B_EXTF] = ext_hit;
  assign flag_set[B_PCHF] = chg_hit;

  irq_flag_reg #(.PCHF_RST(PCHF_RST)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .flag_set (flag_set),
    .accept   (vec_take),
    .ret      (ret_strobe),
    .q        (reg_q)
  );

  assign sw_rdata = reg_q;
  assign irq_req  = req_calc(reg_q, wc_flag);
  assign vec_take = irq_req & irq_ack;
  assign vec_addr = PC_W'(VEC_ADDR);
  assign push_pc  = cur_pc;
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_wr,
  input logic [7:0] sw_rdata,
  input logic       tmr_ovf,
  input logic       wc_flag,
  input logic       ret_strobe,
  input logic       irq_req,
  input logic       vec_take,
  input logic       ext_hit,
  input logic       chg_hit
);
  a_r3_tmr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> sw_rdata[2]);
  a_r4_pin_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> sw_rdata[1]);
  a_r5_port_sets: assert property (@(posedge clk) disable iff (!rst_n)
    chg_hit |=> sw_rdata[0]);
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((sw_rdata[2:0] & $past(sw_rdata[2:0])) == $past(sw_rdata[2:0])));
  a_r7_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((|(sw_rdata[5:3] & sw_rdata[2:0])) || (sw_rdata[6] && wc_flag)));
  a_r8_gie_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rdata[7] |-> !irq_req);
  a_r9_take_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> !sw_rdata[7]);
  a_r10_ret_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !vec_take) |=> sw_rdata[7]);
  a_r11_set_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && tmr_ovf) |=> sw_rdata[2]);
endmodule

bind irq_ctrl_unit irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_wr      (sw_wr),
  .sw_rdata   (sw_rdata),
  .tmr_ovf    (tmr_ovf),
  .wc_flag    (wc_flag),
  .ret_strobe (ret_strobe),
  .irq_req    (irq_req),
  .vec_take   (vec_take),
  .ext_hit    (ext_hit),
  .chg_hit    (chg_hit)
);

// File: tb/irq_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_unit_tb_top;
  localparam int PCW = 13;
  localparam logic [PCW-1:0] PC_VAL = 13'h0ABC;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       irq;
    logic       take;
  } sb_item_t;

  logic           clk = 1'b0;
  logic           rst_n, sw_wr, tmr_ovf, ext_pin, ext_rise_sel, wc_flag;
  logic           irq_ack, ret_strobe, irq_req, vec_take;
  logic [7:0]     sw_wdata, sw_rdata;
  logic [3:0]     port_pins;
  logic [PCW-1:0] cur_pc, vec_addr, push_pc;

  sb_item_t sb_q[$];
  sb_item_t cur;
  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  bit  bad;

  always #10 clk = ~clk;

  irq_ctrl_unit #(.PC_W(PCW), .VEC_ADDR(4), .PORT_W(4), .SYNC_STAGES(2), .PCHF_RST(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .tmr_ovf(tmr_ovf), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel), .port_pins(port_pins),
    .wc_flag(wc_flag), .cur_pc(cur_pc), .irq_ack(irq_ack), .ret_strobe(ret_strobe),
    .irq_req(irq_req), .vec_take(vec_take), .vec_addr(vec_addr), .push_pc(push_pc)
  );

  // monitor: pops each expectation and compares against the ports
  initial forever begin
    wait (sb_q.size() != 0);
    cur = sb_q.pop_front();
    n_run++;
    bad = 1'b0;
    if (sw_rdata !== cur.rd) begin
      $display("FAIL %s rdata act=%h exp=%h", cur.tag, sw_rdata, cur.rd); bad = 1'b1;
    end
    if (irq_req !== cur.irq) begin
      $display("FAIL %s irq_req act=%b exp=%b", cur.tag, irq_req, cur.irq); bad = 1'b1;
    end
    if (vec_take !== cur.take) begin
      $display("FAIL %s vec_take act=%b exp=%b", cur.tag, vec_take, cur.take); bad = 1'b1;
    end
    if (vec_addr !== 13'h004) begin
      $display("FAIL %s vec_addr act=%h exp=004", cur.tag, vec_addr); bad = 1'b1;
    end
    if (push_pc !== PC_VAL) begin
      $display("FAIL %s push_pc act=%h exp=%h", cur.tag, push_pc, PC_VAL); bad = 1'b1;
    end
    if (bad) n_fail++;
  end

  task automatic expect_state(input string tag, input logic [7:0] rd, input logic irq, input logic take);
    sb_item_t it;
    it.tag = tag; it.rd = rd; it.irq = irq; it.take = take;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [7:0] v);
    sw_wr = 1'b1; sw_wdata = v;
    tick(1);
    sw_wr = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; sw_wr = 1'b0; sw_wdata = '0; tmr_ovf = 1'b0; ext_pin = 1'b0;
    ext_rise_sel = 1'b1; port_pins = '0; wc_flag = 1'b0; cur_pc = PC_VAL;
    irq_ack = 1'b0; ret_strobe = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    expect_state("R1 reset", 8'h00, 1'b0, 1'b0);

    // R2 / R7: full write, enabled timer flag requests
    wr(8'hA5);
    expect_state("R2 write A5 / R7", 8'hA5, 1'b1, 1'b0);
    wr(8'h00);
    expect_state("R2 write clears", 8'h00, 1'b0, 1'b0);

    // R3 / R8 / R6
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    expect_state("R3 timer flag", 8'h04, 1'b0, 1'b0);
    tick(4);
    expect_state("R6 timer flag held", 8'h04, 1'b0, 1'b0);
    wr(8'h00);

    // R4 rising edge selected
    ext_rise_sel = 1'b1; ext_pin = 1'b1;
    tick(2);
    expect_state("R4 not yet", 8'h00, 1'b0, 1'b0);
    tick(1);
    expect_state("R4 rising", 8'h02, 1'b0, 1'b0);
    wr(8'h00);
    ext_pin = 1'b0; tick(4);
    expect_state("R4 falling ignored", 8'h00, 1'b0, 1'b0);
    ext_rise_sel = 1'b0; ext_pin = 1'b1; tick(4);
    expect_state("R4 rising ignored", 8'h00, 1'b0, 1'b0);
    ext_pin = 1'b0; tick(3);
    expect_state("R4 falling", 8'h02, 1'b0, 1'b0);
    wr(8'h00);

    // R5 port change both directions
    port_pins = 4'b0100; tick(3);
    expect_state("R5 port rise", 8'h01, 1'b0, 1'b0);
    wr(8'h00);
    port_pins = 4'b0000; tick(3);
    expect_state("R5 port fall", 8'h01, 1'b0, 1'b0);
    wr(8'h00);
    tick(4);
    expect_state("R5 steady", 8'h00, 1'b0, 1'b0);

    // R7 write-complete input, R8 gate
    wr(8'hC0);
    expect_state("R7 wc low", 8'hC0, 1'b0, 1'b0);
    wc_flag = 1'b1;
    expect_state("R7 wc high", 8'hC0, 1'b1, 1'b0);
    wr(8'h40);
    expect_state("R8 gie low", 8'h40, 1'b0, 1'b0);
    wc_flag = 1'b0;

    // R9 acceptance
    wr(8'hA4);
    irq_ack = 1'b1;
    expect_state("R9 take", 8'hA4, 1'b1, 1'b1);
    tick(1); irq_ack = 1'b0;
    expect_state("R9 gie cleared", 8'h24, 1'b0, 1'b0);

    // R10 return
    ret_strobe = 1'b1; tick(1); ret_strobe = 1'b0;
    expect_state("R10 return", 8'hA4, 1'b1, 1'b0);

    // R11 set wins over software clear
    wr(8'h00);
    sw_wr = 1'b1; sw_wdata = 8'h00; tmr_ovf = 1'b1;
    tick(1);
    sw_wr = 1'b0; tmr_ovf = 1'b0;
    expect_state("R11 set wins", 8'h04, 1'b0, 1'b0);

    // R9 acknowledge with no request
    wr(8'h80);
    irq_ack = 1'b1;
    expect_state("R9 ack idle", 8'h80, 1'b0, 1'b0);
    tick(1); irq_ack = 1'b0;
    expect_state("R9 ack idle gie kept", 8'h80, 1'b0, 1'b0);

    tick(1);
    finish_up();
  end
endmodule